// File: doc/BRIEF.md
# Block Memory Responder with Stall Injection

This block stands in for a local memory bank on the far side of a simple memory-mapped request port. A requester drives a read strobe, a write strobe and a block address. Every transfer moves one 64-byte block over a 512-bit data bus, and a 64-bit byte-enable mask chooses which bytes of a write land in storage. Storage is an internal array of `2**ADDR_W` blocks. Byte `i` of a block sits at bus bits `[8*i+7:8*i]`, so block address `a` covers byte addresses `64*a` to `64*a+63`.

Accepted reads are held in an ordered pending list, each with its own countdown timer. When a timer expires, the read comes back on a one-cycle data-valid pulse. The block pushes back with its wait-request output in two cases. The first is a deterministic schedule driven by a free-running cycle counter. The second is when the pending list is full. This lets a device under test be exercised against both regular and congestion-driven back-pressure. A bank-select input is present. Only bank zero exists, and a checker flags any accepted access that names another bank.

Top module: `blk_mem_responder`

## Requirements
- R1: Address `a` selects block `a` of the internal store. Byte `i` of the block travels on data bits `[8*i+7:8*i]`, and a read returns the block last written to that address.
- R2: An accepted write changes only the bytes whose bit `i` in `mem_be` is 1. All other bytes of the block keep their value.
- R3: An accepted read produces exactly one `mem_rvalid` pulse, `LATENCY` rising edges after the edge that accepted it. At most one response leaves per cycle. Among reads whose timers have expired, the one that entered the list earliest returns first.
- R4: Let `n` be the number of rising edges since the last reset edge. `mem_waitreq` is 1 in every cycle where `(n / STALL_DIV) mod STALL_PERIOD == 0`.
- R5: `mem_waitreq` is 1 whenever `QDEPTH` or more reads are outstanding. The pending list never holds more than `QDEPTH` entries.
- R6: In a cycle with `mem_waitreq` high, a presented read or write is dropped. Storage does not change and no response is created.
- R7: Read data is captured when the read is accepted. If a write is accepted in the same cycle, that write's bytes are merged in before the capture.
- R8: `mem_bank` must be 0 whenever a read or write is accepted. A nonzero bank on an accepted access is a checker violation.
- R9: A synchronous reset empties the pending list, clears `mem_rvalid` and restarts the stall schedule at `n = 0`. Storage contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_read | input | 1 | Read request strobe |
| mem_write | input | 1 | Write request strobe |
| mem_addr | input | ADDR_W | Block address |
| mem_wdata | input | 512 | Write data, byte i on bits [8i+7:8i] |
| mem_be | input | 64 | Byte enables for writes |
| mem_bank | input | BANK_W | Bank select, must be 0 on accepted access |
| mem_waitreq | output | 1 | Back-pressure; request not taken while high |
| mem_rvalid | output | 1 | Read response valid, one cycle per read |
| mem_rdata | output | 512 | Read response data |

## Verification
The bench builds the block with `ADDR_W=5`, `QDEPTH=8`, `LATENCY=20`, `STALL_DIV=2` and `STALL_PERIOD=16`. A 20-cycle latency against an 8-entry list means ordinary random read traffic fills the list. This puts full-list back-pressure within reach alongside the periodic stall window, which opens every 32 cycles. The 32-block store is small enough to be initialised completely and then hit repeatedly by random partial writes, same-cycle read/write pairs and reads issued during stall windows with a nonzero bank select.

// File: rtl/mem_resp_pkg.sv
package mem_resp_pkg;

   localparam int unsigned BLK_BYTES = 64;
   localparam int unsigned BLK_BITS  = BLK_BYTES * 8;

   typedef logic [BLK_BITS-1:0]  blk_t;
   typedef logic [BLK_BYTES-1:0] ben_t;

   // Merge enabled bytes of new_v over old_v
   function automatic blk_t blk_merge(input blk_t old_v, input blk_t new_v, input ben_t be);
      blk_t res;
      res = old_v;
      for (int b = 0; b < int'(BLK_BYTES); b++) begin
         if (be[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
      end
      return res;
   endfunction

endpackage

// File: rtl/mem_resp_store.sv
module mem_resp_store
   import mem_resp_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  blk_t              wdata,
   input  ben_t              be,
   output blk_t              rd_sample
);

   localparam int DEPTH = 1 << ADDR_W;

   blk_t ram [DEPTH];
   blk_t cur;

   assign cur       = ram[addr];
   // same-cycle write is visible to the read capture
   assign rd_sample = wr_en ? blk_merge(cur, wdata, be) : cur;

   always_ff @(posedge clk) begin
      if (wr_en) ram[addr] <= blk_merge(cur, wdata, be);
   end

endmodule

// File: rtl/mem_resp_stall_gen.sv
module mem_resp_stall_gen #(
   parameter int STALL_DIV    = 2,
   parameter int STALL_PERIOD = 16,
   parameter bit STALL_EN     = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic list_full,
   output logic waitreq
);

   localparam int SPAN = STALL_DIV * STALL_PERIOD;
   localparam int CW   = (SPAN > 1) ? $clog2(SPAN) : 1;

   logic [CW-1:0] phase_q;
   logic          tick_stall;

   always_ff @(posedge clk) begin
      if (rst)                            phase_q <= '0;
      else if (phase_q == CW'(SPAN - 1))  phase_q <= '0;
      else                                phase_q <= phase_q + 1'b1;
   end

   generate
      if (STALL_EN) begin : g_periodic
         assign tick_stall = (phase_q < CW'(STALL_DIV));
      end else begin : g_no_periodic
         assign tick_stall = 1'b0;
      end
   endgenerate

   assign waitreq = tick_stall | list_full;

endmodule

// File: rtl/mem_resp_pending.sv
module mem_resp_pending
   import mem_resp_pkg::*;
#(
   parameter int QDEPTH  = 16,
   parameter int LATENCY = 4,
   localparam int NW     = $clog2(QDEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  blk_t          push_data,
   output logic          rsp_valid,
   output blk_t          rsp_data,
   output logic [NW-1:0] count,
   output logic          full
);

   localparam int CW = $clog2(LATENCY + 1);
   localparam int IW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

   logic [QDEPTH-1:0] vld_q, vld_sh, vld_d;
   logic [CW-1:0]     tmr_q [QDEPTH];
   logic [CW-1:0]     tmr_dec [QDEPTH];
   logic [CW-1:0]     tmr_sh [QDEPTH];
   logic [CW-1:0]     tmr_d [QDEPTH];
   blk_t              dat_q [QDEPTH];
   blk_t              dat_sh [QDEPTH];
   blk_t              dat_d [QDEPTH];
   logic [QDEPTH-1:0] ready;
   logic [QDEPTH-1:0] take_nx;
   logic [NW-1:0]     num_q, num_d, wr_pos;
   logic [IW-1:0]     sel;
   logic              pop;

   genvar gi;
   generate
      for (gi = 0; gi < QDEPTH; gi++) begin : g_slot
         assign tmr_dec[gi] = (tmr_q[gi] == '0) ? '0 : tmr_q[gi] - 1'b1;
         assign ready[gi]   = vld_q[gi] && (tmr_dec[gi] == '0);
         assign take_nx[gi] = pop && (sel <= IW'(gi));
         if (gi < QDEPTH - 1) begin : g_mid
            assign vld_sh[gi] = take_nx[gi] ? vld_q[gi+1]   : vld_q[gi];
            assign tmr_sh[gi] = take_nx[gi] ? tmr_dec[gi+1] : tmr_dec[gi];
            assign dat_sh[gi] = take_nx[gi] ? dat_q[gi+1]   : dat_q[gi];
         end else begin : g_last
            assign vld_sh[gi] = take_nx[gi] ? 1'b0 : vld_q[gi];
            assign tmr_sh[gi] = tmr_dec[gi];
            assign dat_sh[gi] = dat_q[gi];
         end
      end
   endgenerate

   // lowest index among expired entries is the oldest ready one
   always_comb begin
      pop = 1'b0;
      sel = '0;
      for (int i = QDEPTH - 1; i >= 0; i--) begin
         if (ready[i]) begin
            pop = 1'b1;
            sel = IW'(i);
         end
      end
   end

   always_comb begin
      wr_pos = num_q - NW'(pop);
      vld_d  = vld_sh;
      for (int i = 0; i < QDEPTH; i++) begin
         tmr_d[i] = tmr_sh[i];
         dat_d[i] = dat_sh[i];
         if (push && (wr_pos == NW'(i))) begin
            vld_d[i] = 1'b1;
            tmr_d[i] = CW'(LATENCY);
            dat_d[i] = push_data;
         end
      end
      num_d = num_q - NW'(pop) + NW'(push);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q     <= '0;
         num_q     <= '0;
         rsp_valid <= 1'b0;
      end else begin
         vld_q     <= vld_d;
         num_q     <= num_d;
         rsp_valid <= pop;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < QDEPTH; i++) begin
         tmr_q[i] <= tmr_d[i];
         dat_q[i] <= dat_d[i];
      end
      if (pop) rsp_data <= dat_q[sel];
   end

   assign count = num_q;
   assign full  = (num_q >= NW'(QDEPTH));

endmodule

// File: rtl/blk_mem_responder.sv
module blk_mem_responder
   import mem_resp_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int BANK_W       = 2,
   parameter int QDEPTH       = 16,
   parameter int LATENCY      = 4,
   parameter int STALL_DIV    = 2,
   parameter int STALL_PERIOD = 16,
   parameter bit STALL_EN     = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mem_read,
   input  logic                mem_write,
   input  logic [ADDR_W-1:0]   mem_addr,
   input  logic [511:0]        mem_wdata,
   input  logic [63:0]         mem_be,
   input  logic [BANK_W-1:0]   mem_bank,
   output logic                mem_waitreq,
   output logic                mem_rvalid,
   output logic [511:0]        mem_rdata
);

   localparam int NW = $clog2(QDEPTH + 1);

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("blk_mem_responder: ADDR_W out of range");
      end
      if (QDEPTH < 2) begin : g_bad_depth
         $error("blk_mem_responder: QDEPTH must be at least 2");
      end
      if (LATENCY < 1) begin : g_bad_lat
         $error("blk_mem_responder: LATENCY must be at least 1");
      end
      if (STALL_DIV < 1 || STALL_PERIOD < 1) begin : g_bad_stall
         $error("blk_mem_responder: stall divider and period must be positive");
      end
   endgenerate

   logic          rd_acc, wr_acc;
   logic          list_full;
   logic [NW-1:0] pend_cnt;
   blk_t          rd_sample;
   logic          unused_bank;

   assign unused_bank = |mem_bank;
   assign rd_acc      = mem_read  && !mem_waitreq;
   assign wr_acc      = mem_write && !mem_waitreq;

   mem_resp_stall_gen #(
      .STALL_DIV    (STALL_DIV),
      .STALL_PERIOD (STALL_PERIOD),
      .STALL_EN     (STALL_EN)
   ) i_stall (
      .clk       (clk),
      .rst       (rst),
      .list_full (list_full),
      .waitreq   (mem_waitreq)
   );

   mem_resp_store #(
      .ADDR_W (ADDR_W)
   ) i_store (
      .clk       (clk),
      .wr_en     (wr_acc),
      .addr      (mem_addr),
      .wdata     (mem_wdata),
      .be        (mem_be),
      .rd_sample (rd_sample)
   );

   mem_resp_pending #(
      .QDEPTH  (QDEPTH),
      .LATENCY (LATENCY)
   ) i_pend (
      .clk       (clk),
      .rst       (rst),
      .push      (rd_acc),
      .push_data (rd_sample),
      .rsp_valid (mem_rvalid),
      .rsp_data  (mem_rdata),
      .count     (pend_cnt),
      .full      (list_full)
   );

endmodule

// File: rtl/blk_mem_responder_chk.sv
module blk_mem_responder_chk #(
   parameter int QDEPTH = 16,
   parameter int BANK_W = 2,
   parameter int NW     = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              mem_read,
   input logic              mem_write,
   input logic              mem_waitreq,
   input logic [BANK_W-1:0] mem_bank,
   input logic              mem_rvalid,
   input logic [NW-1:0]     pend_cnt
);

   // R8
   a_r8_bank_zero: assert property (@(posedge clk) disable iff (rst)
      (mem_read || mem_write) && !mem_waitreq |-> mem_bank == '0);

   // R5
   a_r5_full_stalls: assert property (@(posedge clk) disable iff (rst)
      pend_cnt >= NW'(QDEPTH) |-> mem_waitreq);

   // R5
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
      pend_cnt <= NW'(QDEPTH));

   // R6
   a_r6_stall_no_growth: assert property (@(posedge clk) disable iff (rst)
      mem_waitreq |=> pend_cnt <= $past(pend_cnt));

   // R3
   a_r3_rsp_has_entry: assert property (@(posedge clk) disable iff (rst)
      mem_rvalid |-> $past(pend_cnt) != '0);

   // R9
   a_r9_reset_clears: assert property (@(posedge clk)
      rst |=> (pend_cnt == '0) && !mem_rvalid);

endmodule

bind blk_mem_responder blk_mem_responder_chk #(
   .QDEPTH (QDEPTH),
   .BANK_W (BANK_W),
   .NW     (NW)
) i_chk (
   .clk         (clk),
   .rst         (rst),
   .mem_read    (mem_read),
   .mem_write   (mem_write),
   .mem_waitreq (mem_waitreq),
   .mem_bank    (mem_bank),
   .mem_rvalid  (mem_rvalid),
   .pend_cnt    (pend_cnt)
);

// File: tb/test_blk_mem_responder.sv
module test_blk_mem_responder;
   import mem_resp_pkg::*;

   localparam int AW   = 5;
   localparam int BW   = 2;
   localparam int Q    = 8;
   localparam int LAT  = 20;
   localparam int DIV  = 2;
   localparam int PER  = 16;
   localparam int NBLK = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          mem_read = 1'b0, mem_write = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [511:0]  mem_wdata = '0;
   logic [63:0]   mem_be = '0;
   logic [BW-1:0] mem_bank = '0;
   logic          mem_waitreq, mem_rvalid;
   logic [511:0]  mem_rdata;

   blk_mem_responder #(
      .ADDR_W (AW), .BANK_W (BW), .QDEPTH (Q), .LATENCY (LAT),
      .STALL_DIV (DIV), .STALL_PERIOD (PER), .STALL_EN (1'b1)
   ) i_blk_mem_responder (
      .clk (clk), .rst (rst), .mem_read (mem_read), .mem_write (mem_write),
      .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_be (mem_be),
      .mem_bank (mem_bank), .mem_waitreq (mem_waitreq),
      .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata)
   );

   always #4 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   int    edge_n = 0;
   bit    done   = 0;
   string cur_tag = "R1";
   blk_t  mdl_mem [NBLK];
   blk_t  exp_dat [$];
   int    exp_due [$];

   function automatic blk_t rand_blk();
      blk_t v;
      for (int w = 0; w < 16; w++) v[w*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic bit exp_stall(input int n, input int outstanding);
      return ((n % (DIV * PER)) < DIV) || (outstanding >= Q);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_outputs();
      bit ev;
      ev = (exp_due.size() > 0) && (exp_due[0] == edge_n);
      check(mem_rvalid == ev, "R3 response valid timing", 512'(mem_rvalid), 512'(ev));
      if (ev) begin
         check(mem_rdata == exp_dat[0], {cur_tag, " R3 response data"}, mem_rdata, exp_dat[0]);
         void'(exp_dat.pop_front());
         void'(exp_due.pop_front());
      end
      ev = exp_stall(edge_n, exp_due.size());
      check(mem_waitreq == ev, (exp_due.size() >= Q) ? "R5 waitreq full" : "R4 waitreq schedule",
            512'(mem_waitreq), 512'(ev));
   endtask

   task automatic step(input logic rd, input logic wr, input logic [AW-1:0] a, input blk_t wd,
                       input ben_t be, input logic [BW-1:0] bk, output bit acc);
      mem_read = rd; mem_write = wr; mem_addr = a; mem_wdata = wd; mem_be = be; mem_bank = bk;
      acc = !mem_waitreq;
      @(posedge clk);
      edge_n++;
      if (acc && wr) mdl_mem[a] = blk_merge(mdl_mem[a], wd, be);
      if (acc && rd) begin
         exp_dat.push_back(mdl_mem[a]);
         exp_due.push_back(edge_n + LAT);
      end
      @(negedge clk);
      mem_read = 1'b0; mem_write = 1'b0;
      check_outputs();
   endtask

   task automatic issue(input logic rd, input logic wr, input logic [AW-1:0] a, input blk_t wd, input ben_t be);
      bit acc;
      acc = 0;
      while (!acc) step(rd, wr, a, wd, be, '0, acc);
   endtask

   task automatic idle(input int n);
      bit acc;
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, '0, '0, '0, acc);
   endtask

   task automatic do_reset();
      rst = 1'b1; mem_read = 1'b0; mem_write = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      exp_dat.delete();
      exp_due.delete();
      edge_n = 0;
      check(mem_rvalid == 1'b0, "R9 no response after reset", 512'(mem_rvalid), 512'(0));
      check(mem_waitreq == 1'b1, "R9 R4 stall at schedule start", 512'(mem_waitreq), 512'(1));
   endtask

   initial begin
      bit   acc;
      blk_t v;
      void'($urandom(32'h5eed_1234));
      @(negedge clk);
      do_reset();

      // R1: fill every block
      cur_tag = "R1";
      for (int b = 0; b < NBLK; b++) issue(1'b0, 1'b1, AW'(b), rand_blk(), '1);
      for (int b = 0; b < NBLK; b++) issue(1'b1, 1'b0, AW'(b), '0, '0);
      idle(LAT + 2);

      // R2: partial writes, including an empty mask
      cur_tag = "R2";
      issue(1'b0, 1'b1, AW'(3), rand_blk(), 64'h0000_0000_0000_0001);
      issue(1'b0, 1'b1, AW'(4), rand_blk(), 64'h8000_0000_0000_0000);
      issue(1'b0, 1'b1, AW'(5), rand_blk(), 64'h0);
      issue(1'b0, 1'b1, AW'(6), rand_blk(), 64'hA5A5_0F0F_FF00_3C3C);
      for (int b = 3; b < 7; b++) issue(1'b1, 1'b0, AW'(b), '0, '0);
      idle(LAT + 2);

      // R7: read and write to the same block in one cycle
      cur_tag = "R7";
      issue(1'b1, 1'b1, AW'(9), rand_blk(), 64'h00FF_00FF_00FF_00FF);
      issue(1'b1, 1'b1, AW'(10), rand_blk(), '1);
      idle(LAT + 2);

      // R6 and R8: requests in stall windows carry a nonzero bank and must be dropped
      cur_tag = "R6 R8";
      for (int k = 0; k < 3; k++) begin
         while (!mem_waitreq) idle(1);
         v = rand_blk();
         step(1'b1, 1'b1, AW'(7), v, '1, BW'(k + 1), acc);
         check(acc == 1'b0, "R6 request taken during stall", 512'(acc), 512'(0));
      end
      issue(1'b1, 1'b0, AW'(7), '0, '0);
      idle(LAT + 2);

      // R5: back-to-back reads fill the list
      cur_tag = "R5";
      for (int k = 0; k < 40; k++) step(1'b1, 1'b0, AW'(k), '0, '0, '0, acc);
      idle(LAT + 2);

      // R9: reset with reads outstanding drops them
      for (int k = 0; k < 6; k++) issue(1'b1, 1'b0, AW'(k + 11), '0, '0);
      do_reset();
      idle(LAT + 4);

      // random mix
      cur_tag = "R1 R2 R7";
      for (int k = 0; k < 4000; k++) begin
         logic       rd, wr;
         logic [BW-1:0] bk;
         ben_t       be;
         rd = ($urandom % 100) < 50;
         wr = ($urandom % 100) < 35;
         case ($urandom % 4)
            0:       be = '1;
            1:       be = '0;
            default: be = {$urandom, $urandom};
         endcase
         bk = mem_waitreq ? BW'($urandom) : '0;
         step(rd, wr, AW'($urandom), rand_blk(), be, bk, acc);
      end
      idle(LAT + 4);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule